// File: doc/BRIEF.md
# I2C Master SCL and Data Timing Generator

This block produces the master clock waveform of an I2C bus, together with the moments at which the data line may change and may be sampled. It reads its timing from a 32-bit word with five fields: a prescaler, a data setup delay, a data hold delay, a clock high count and a clock low count. All phases are measured in units of (prescaler + 1) kernel clocks, and every phase is timed by one shared prescaler.

A byte-level sequencer raises `run` to request clock pulses. It acts on the one-cycle strobes: SCL pulled low, SCL released, SDA may change, SDA may be sampled. The open-drain SCL line is read back through a two-stage synchroniser and a digital noise filter. Each low or high count starts only after the filtered line shows the new level. A slave that holds SCL low therefore stretches the low phase, and the measured high time always starts from the real rising edge. Software clears `enable` before it rewrites the timing word. The word is captured only while the block is disabled.

Top module: `i2c_scl_timer`

## Requirements
- R1: The timing word is decoded as prescaler P = bits 31:28, setup count SU = bits 23:20, hold count HD = bits 19:16, high count HI = bits 15:8 and low count LO = bits 7:0; bits 27:24 are ignored. The word is copied while `enable` is low, and changes made while `enable` is high have no effect on any timing.
- R2: During and after reset, `scl_drive_low` and all four strobes are 0.
- R3: Let the sync delay S be DNF + 3 kernel clocks. With no stretching, `scl_drive_low` stays high for S + max((LO+1)(P+1), (HD+SU+1)(P+1)+1) cycles.
- R4: With no stretching, `scl_drive_low` stays low between pulses for S + (HI+1)(P+1) cycles.
- R5: `sda_change_stb` pulses once per low phase, HD(P+1)+1+S cycles after `scl_drive_low` rises, while SCL is driven low.
- R6: SCL is released no sooner than (SU+1)(P+1) cycles after `sda_change_stb`. When HD and SU need more time than LO, the low phase is lengthened to give that time.
- R7: If the SCL line is held low after release, the high count starts from the point the line actually rises. The next `scl_drive_low` then comes S + (HI+1)(P+1) cycles after that rise.
- R8: `sda_sample_stb` pulses S cycles after the SCL line rises, while SCL is released.
- R9: When `run` is low at the end of a high phase, SCL stays released and no further fall strobe occurs.
- R10: Each strobe lasts one cycle and no two strobes coincide. `scl_fall_stb` marks the cycle in which `scl_drive_low` rises, and `scl_rise_stb` marks the cycle in which it falls by a normal release.
- R11: When `enable` goes low, `scl_drive_low` is 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; timing word copied while low |
| run | input | 1 | Sequencer request for further clock pulses |
| timing_word | input | 32 | Prescaler, setup, hold, high and low counts |
| scl_line_in | input | 1 | Observed SCL bus level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_fall_stb | output | 1 | Pulse: SCL pull-down started |
| scl_rise_stb | output | 1 | Pulse: SCL released |
| sda_change_stb | output | 1 | Pulse: SDA may change now |
| sda_sample_stb | output | 1 | Pulse: SDA may be sampled now |

## Verification
The hardest case to reach is one where the low phase is set by the hold and setup counts rather than the low count, while a slave also stretches the clock after release. The bench reaches it with configurations whose HD+SU term is larger than LO, and by holding the modelled bus line low for a chosen number of cycles after `scl_rise_stb`. Each width is measured in kernel clocks and compared with the arithmetic result, across several prescaler values. A garbage timing word is written during every run to show that it is ignored.

// File: rtl/i2c_tim_pkg.sv
`timescale 1ns/1ps
package i2c_tim_pkg;

    localparam int PRE_W  = 4;
    localparam int CNT_W  = 8;
    localparam int DLY_W  = 4;
    localparam int UNIT_W = CNT_W + 1;

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic [3:0]       unused_nib;
        logic [DLY_W-1:0] setup_u;
        logic [DLY_W-1:0] hold_u;
        logic [CNT_W-1:0] high_u;
        logic [CNT_W-1:0] low_u;
    } tim_word_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAIT_LO,
        PH_CNT_LO,
        PH_WAIT_HI,
        PH_CNT_HI
    } phase_e;

    function automatic logic [UNIT_W-1:0] setup_units(
        input logic [DLY_W-1:0] hold_u,
        input logic [DLY_W-1:0] setup_u
    );
        return UNIT_W'(hold_u) + UNIT_W'(setup_u) + UNIT_W'(1);
    endfunction

endpackage

// File: rtl/scl_in_filter.sv
`timescale 1ns/1ps
module scl_in_filter #(
    parameter int DNF = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic filt_o
);
    logic sync1_q, sync2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
        end else begin
            sync1_q <= line_i;
            sync2_q <= sync1_q;
        end
    end

    generate
        if (DNF == 0) begin : g_nofilt
            assign filt_o = sync2_q;
        end else begin : g_filt
            localparam int CW = $clog2(DNF + 1);
            logic [CW-1:0] cnt_q;
            logic          filt_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt_q  <= '0;
                    filt_q <= 1'b1;
                end else if (sync2_q != filt_q) begin
                    if (cnt_q == CW'(DNF - 1)) begin
                        filt_q <= sync2_q;
                        cnt_q  <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else begin
                    cnt_q <= '0;
                end
            end
            assign filt_o = filt_q;
        end
    endgenerate
endmodule

// File: rtl/unit_timebase.sv
`timescale 1ns/1ps
module unit_timebase
    import i2c_tim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic [PRE_W-1:0]  presc_i,
    output logic [PRE_W-1:0]  pre_o,
    output logic [UNIT_W-1:0] unit_o
);
    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            pre_o  <= '0;
            unit_o <= '0;
        end else if (pre_o == presc_i) begin
            pre_o <= '0;
            if (unit_o != '1) unit_o <= unit_o + 1'b1;
        end else begin
            pre_o <= pre_o + 1'b1;
        end
    end
endmodule

// File: rtl/scl_phase_fsm.sv
`timescale 1ns/1ps
module scl_phase_fsm
    import i2c_tim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              run_i,
    input  logic              filt_i,
    input  logic [PRE_W-1:0]  presc_i,
    input  logic [DLY_W-1:0]  setup_i,
    input  logic [DLY_W-1:0]  hold_i,
    input  logic [CNT_W-1:0]  high_i,
    input  logic [CNT_W-1:0]  low_i,
    input  logic [PRE_W-1:0]  pre_i,
    input  logic [UNIT_W-1:0] unit_i,
    output logic              clear_o,
    output logic              scl_low_o,
    output logic              fall_o,
    output logic              rise_o,
    output logic              chg_o,
    output logic              smp_o
);
    phase_e state_q;
    logic   lo_done, su_done, chg_now, hi_done;

    always_comb begin
        lo_done = (unit_i > UNIT_W'(low_i)) ||
                  ((unit_i == UNIT_W'(low_i)) && (pre_i == presc_i));
        su_done = unit_i >= setup_units(hold_i, setup_i);
        chg_now = (unit_i == UNIT_W'(hold_i)) && (pre_i == '0);
        hi_done = (unit_i == UNIT_W'(high_i)) && (pre_i == presc_i);
        clear_o = enable_i &&
                  (((state_q == PH_WAIT_LO) && !filt_i) ||
                   ((state_q == PH_WAIT_HI) &&  filt_i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PH_IDLE;
            scl_low_o <= 1'b0;
            fall_o    <= 1'b0;
            rise_o    <= 1'b0;
            chg_o     <= 1'b0;
            smp_o     <= 1'b0;
        end else begin
            fall_o <= 1'b0;
            rise_o <= 1'b0;
            chg_o  <= 1'b0;
            smp_o  <= 1'b0;
            if (!enable_i) begin
                state_q   <= PH_IDLE;
                scl_low_o <= 1'b0;
            end else begin
                unique case (state_q)
                    PH_IDLE: if (run_i) begin
                        state_q   <= PH_WAIT_LO;
                        scl_low_o <= 1'b1;
                        fall_o    <= 1'b1;
                    end
                    PH_WAIT_LO: if (!filt_i) state_q <= PH_CNT_LO;
                    PH_CNT_LO: begin
                        if (chg_now) chg_o <= 1'b1;
                        if (lo_done && su_done) begin
                            state_q   <= PH_WAIT_HI;
                            scl_low_o <= 1'b0;
                            rise_o    <= 1'b1;
                        end
                    end
                    PH_WAIT_HI: if (filt_i) begin
                        state_q <= PH_CNT_HI;
                        smp_o   <= 1'b1;
                    end
                    PH_CNT_HI: if (hi_done) begin
                        if (run_i) begin
                            state_q   <= PH_WAIT_LO;
                            scl_low_o <= 1'b1;
                            fall_o    <= 1'b1;
                        end else begin
                            state_q <= PH_IDLE;
                        end
                    end
                    default: state_q <= PH_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_scl_timer.sv
`timescale 1ns/1ps
module i2c_scl_timer
    import i2c_tim_pkg::*;
#(
    parameter int DNF = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        run,
    input  logic [31:0] timing_word,
    input  logic        scl_line_in,
    output logic        scl_drive_low,
    output logic        scl_fall_stb,
    output logic        scl_rise_stb,
    output logic        sda_change_stb,
    output logic        sda_sample_stb
);
    tim_word_t          tw_q;
    logic               filt;
    logic               tb_clear;
    logic [PRE_W-1:0]   pre;
    logic [UNIT_W-1:0]  unit;

    always_ff @(posedge clk) begin
        if (rst)          tw_q <= '0;
        else if (!enable) tw_q <= tim_word_t'(timing_word);
    end

    scl_in_filter #(.DNF(DNF)) u_filter (
        .clk    (clk),
        .rst    (rst),
        .line_i (scl_line_in),
        .filt_o (filt)
    );

    unit_timebase u_timebase (
        .clk     (clk),
        .rst     (rst),
        .clear_i (tb_clear),
        .presc_i (tw_q.presc),
        .pre_o   (pre),
        .unit_o  (unit)
    );

    scl_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .enable_i  (enable),
        .run_i     (run),
        .filt_i    (filt),
        .presc_i   (tw_q.presc),
        .setup_i   (tw_q.setup_u),
        .hold_i    (tw_q.hold_u),
        .high_i    (tw_q.high_u),
        .low_i     (tw_q.low_u),
        .pre_i     (pre),
        .unit_i    (unit),
        .clear_o   (tb_clear),
        .scl_low_o (scl_drive_low),
        .fall_o    (scl_fall_stb),
        .rise_o    (scl_rise_stb),
        .chg_o     (sda_change_stb),
        .smp_o     (sda_sample_stb)
    );
endmodule

// File: rtl/i2c_scl_timer_chk.sv
`timescale 1ns/1ps
module i2c_scl_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        enable,
    input logic        scl_low,
    input logic        fall_stb,
    input logic        rise_stb,
    input logic        chg_stb,
    input logic        smp_stb,
    input logic [31:0] tw
);
    logic [15:0] since_chg;
    logic        chg_seen;
    logic [15:0] need;

    assign need = 16'((tw[23:20] + 5'd1) * (tw[31:28] + 5'd1));

    always_ff @(posedge clk) begin
        if (rst) begin
            since_chg <= '0;
            chg_seen  <= 1'b0;
        end else begin
            if (chg_stb) begin
                since_chg <= 16'd1;
                chg_seen  <= 1'b1;
            end else begin
                if (since_chg != '1) since_chg <= since_chg + 1'b1;
                if (!scl_low) chg_seen <= 1'b0;
            end
        end
    end

    assert_tw_frozen_R1: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable)) |-> $stable(tw));

    assert_chg_in_low_R5: assert property (@(posedge clk) disable iff (rst)
        chg_stb |-> scl_low);

    assert_setup_window_R6: assert property (@(posedge clk) disable iff (rst)
        ($fell(scl_low) && chg_seen && $past(enable) && enable) |-> (since_chg >= need));

    assert_sample_in_high_R8: assert property (@(posedge clk) disable iff (rst)
        smp_stb |-> !scl_low);

    assert_single_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fall_stb, rise_stb, chg_stb, smp_stb}));

    assert_fall_marked_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_low) |-> fall_stb);

    assert_rise_marked_R10: assert property (@(posedge clk) disable iff (rst)
        ($fell(scl_low) && $past(enable)) |-> rise_stb);

    assert_disable_release_R11: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !scl_low);
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .scl_low  (scl_drive_low),
    .fall_stb (scl_fall_stb),
    .rise_stb (scl_rise_stb),
    .chg_stb  (sda_change_stb),
    .smp_stb  (sda_sample_stb),
    .tw       (tw_q)
);

// File: tb/test_i2c_scl_timer.sv
`timescale 1ns/1ps
module test_i2c_scl_timer;
    localparam int DNF = 1;
    localparam int SY  = DNF + 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        run = 1'b0;
    logic        hold = 1'b0;
    logic [31:0] timing_word = '0;
    logic        scl_drive_low, scl_fall_stb, scl_rise_stb;
    logic        sda_change_stb, sda_sample_stb;
    wire         line = !(scl_drive_low || hold);

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    i2c_scl_timer #(.DNF(DNF)) i_i2c_scl_timer (
        .clk            (clk),
        .rst            (rst),
        .enable         (enable),
        .run            (run),
        .timing_word    (timing_word),
        .scl_line_in    (line),
        .scl_drive_low  (scl_drive_low),
        .scl_fall_stb   (scl_fall_stb),
        .scl_rise_stb   (scl_rise_stb),
        .sda_change_stb (sda_change_stb),
        .sda_sample_stb (sda_sample_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lim);
        n_chk++;
        if (act < lim) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic run_cfg(input int p, input int su, input int hd,
                           input int hi, input int lo, input int stretch);
        int tf, tc, tr, tl, ts, tf2, falls, w, lo_main, lo_setup;
        logic [31:0] tw;
        tw = {4'(p), 4'hA, 4'(su), 4'(hd), 8'(hi), 8'(lo)};
        enable = 1'b0; run = 1'b0; hold = 1'b0;
        timing_word = tw;
        repeat (3) @(negedge clk);
        enable = 1'b1; run = 1'b1;
        @(negedge clk);
        while (!scl_drive_low) @(negedge clk);
        tf = cyc;
        chk("R10 fall strobe with pull-down", int'(scl_fall_stb), 1);
        timing_word = ~tw;
        while (!sda_change_stb) @(negedge clk);
        tc = cyc;
        if (stretch > 0) hold = 1'b1;
        while (scl_drive_low) @(negedge clk);
        tr = cyc;
        chk("R10 rise strobe with release", int'(scl_rise_stb), 1);
        repeat (stretch) @(negedge clk);
        hold = 1'b0;
        tl = cyc;
        while (!sda_sample_stb) @(negedge clk);
        ts = cyc;
        while (!scl_drive_low) @(negedge clk);
        tf2 = cyc;
        run = 1'b0;

        lo_main  = (lo + 1) * (p + 1);
        lo_setup = (hd + su + 1) * (p + 1) + 1;
        if (lo_setup > lo_main)
            chk("R6 low stretched for setup, R1 word frozen", tr - tf, SY + lo_setup);
        else
            chk("R3 low width, R1 word frozen", tr - tf, SY + lo_main);
        chk("R5 sda change offset", tc - tf, SY + hd * (p + 1) + 1);
        chk_ge("R6 setup before release", tr - tc, (su + 1) * (p + 1));
        chk("R8 sample offset", ts - tl, SY);
        if (stretch > 0)
            chk("R7 high width after stretch", tf2 - tl, SY + (hi + 1) * (p + 1));
        else
            chk("R4 high width", tf2 - tl, SY + (hi + 1) * (p + 1));

        while (scl_drive_low) @(negedge clk);
        falls = 0;
        w = SY + (hi + 1) * (p + 1) + 8;
        for (int k = 0; k < w; k++) begin
            @(negedge clk);
            if (scl_fall_stb || scl_drive_low) falls++;
        end
        chk("R9 idle after run drops", falls, 0);
        enable = 1'b0;
        timing_word = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 reset pull-down", int'(scl_drive_low), 0);
        chk("R2 reset strobes", int'({scl_fall_stb, scl_rise_stb, sda_change_stb, sda_sample_stb}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 after reset idle", int'(scl_drive_low), 0);

        run_cfg(0, 1, 1, 4, 5, 0);
        run_cfg(1, 0, 2, 3, 6, 0);
        run_cfg(3, 2, 1, 2, 3, 4);
        run_cfg(1, 4, 3, 5, 1, 0);
        run_cfg(2, 0, 0, 0, 0, 7);
        run_cfg(15, 1, 0, 1, 1, 0);
        for (int p = 0; p < 5; p++) run_cfg(p, 0, 1, 1, 2, p);

        timing_word = {4'd2, 4'd0, 4'd1, 4'd1, 8'd3, 8'd9};
        repeat (2) @(negedge clk);
        enable = 1'b1; run = 1'b1;
        while (!scl_drive_low) @(negedge clk);
        repeat (2) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R11 release on disable", int'(scl_drive_low), 0);
        repeat (5) @(negedge clk);
        chk("R11 stays released", int'(scl_drive_low || scl_fall_stb), 0);
        run = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule